// File: doc/BRIEF.md
# Graphics Command Packet Framer

This block sits on a stream of 32-bit graphics command words. Each word arrives on one valid/ready handshake. The block works out where every command packet begins and ends. The opcode is the top byte of a packet's first word. For most opcodes it selects a fixed count of parameter words. Two polyline families instead run until a terminator word turns up. Each word is passed on one cycle after it is accepted, together with a head flag, a tail flag and the class of the packet it belongs to.

A tail flag appears only on the word that really completes a packet. If the input pauses in the middle of a packet, the block keeps its place and continues when words arrive again. It never closes a packet early. Environment-setting commands are single words, and their full word is also stored in a bank of eight registers. The bank is exposed as a flat bus.

The block does no rasterization, drawing or image data movement. After an image-transfer header, the next word is framed as a new command.

Top module: `cmd_framer`

## Requirements
- R1: The opcode is bits 31:24 of a packet's first word, and a fixed-length packet spans 1 + N words. N is 3, 6, 4, 8, 5, 8, 7, 11 for the eight groups of four opcodes from 0x20 to 0x3F in ascending order. The head flag is on word 0, the tail flag is on word N, and parameter words never end a packet early.
- R2: Opcode 0x02 (area fill) spans 3 words.
- R3: Opcodes 0x48–0x4F (flat polyline) end on the first word at index 3 or later for which (word & 0xF000F000) == 0x50005000, and that word is part of the packet. A matching word at index 1 or 2 does not end it.
- R4: Opcodes 0x58–0x5F (shaded polyline) test for the same terminator only at even indices 4, 6, 8, and so on. A matching word at an odd index does not end the packet.
- R5: Opcodes 0xA0–0xDF span 3 words. The class is image-write (6) for 0xA0–0xBF and image-read (7) when (opcode & 0xE0) == 0xC0.
- R6: Opcodes 0x80–0x9F (block copy) span 4 words, with class 5.
- R7: Opcodes 0xE0–0xE7 are single-word packets of class 8. The whole word is stored in environment register (opcode & 7), at env_flat bits [32·i+31 : 32·i]. It is visible one cycle after acceptance, and all other registers keep their values.
- R8: Any other opcode whose count is 0 (for example 0x00, 0x1F, 0x6C–0x6F, 0xE8–0xFF) is a single-word packet of class 0 (no-op) and changes no environment register.
- R9: Each accepted word appears on the mark outputs exactly one cycle after it is accepted. When no word is accepted, mark_valid is 0. Idle cycles inside a packet do not end it or restart it.
- R10: While rst_n is low at a clock edge: in_ready goes to 0, mark_valid goes to 0, all environment registers clear to 0, and any partly framed packet is dropped. The first word accepted after reset is treated as a packet head.
- R11: The classes are: fill 1 (0x02), polygon 2 (0x20–0x3F), line 3 (0x40–0x5F), rectangle 4 (0x60–0x7F). For lines, N is 2 for 0x40–0x47 and 3 for 0x50–0x57. For rectangles, N is 2, 3, 1, 0, 1, 2, 1, 2 for the eight groups of four opcodes from 0x60 in ascending order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input command word |
| in_ready | output | 1 | Block accepts a word (high whenever out of reset) |
| mark_valid | output | 1 | A framed word is presented |
| mark_data | output | 32 | The framed word |
| mark_start | output | 1 | Word is the first of its packet |
| mark_end | output | 1 | Word completes its packet |
| mark_class | output | 4 | Packet class of the word |
| env_flat | output | 256 | Eight environment registers, register i at bits 32·i+31:32·i |

## Verification
Every framing result and every environment-register update is due on the clock edge right after the edge that accepts the word. in_ready rises on the first edge after rst_n is released. The bench drives each word at a falling edge and samples the mark outputs and the environment bus 1 ns after the rising edge that accepts it. That sampling point falls inside the one-cycle window where those registers hold the result for that word. During deliberate idle gaps, the same sampling point confirms that mark_valid is low and that the open packet continues afterwards.

// File: rtl/cmdf_pkg.sv
// Shared constants, types and opcode decode functions for the command framer.
// Assumes 32-bit words with the opcode in the top byte.
package cmdf_pkg;

    localparam int WORD_W    = 32;
    localparam int OP_W      = 8;
    localparam int CNT_W     = 4;
    localparam int ENV_N     = 8;
    localparam int ENV_IDX_W = $clog2(ENV_N);

    localparam logic [WORD_W-1:0] TERM_MASK = 32'hF000_F000;
    localparam logic [WORD_W-1:0] TERM_VAL  = 32'h5000_5000;

    typedef enum logic [3:0] {
        CL_NOP     = 4'd0,
        CL_FILL    = 4'd1,
        CL_POLYGON = 4'd2,
        CL_LINE    = 4'd3,
        CL_RECT    = 4'd4,
        CL_COPY    = 4'd5,
        CL_IMG_WR  = 4'd6,
        CL_IMG_RD  = 4'd7,
        CL_ENV     = 4'd8
    } pkt_class_e;

    typedef enum logic [1:0] {
        TR_FIXED  = 2'd0,
        TR_FLAT   = 2'd1,
        TR_SHADED = 2'd2
    } trail_e;

    // Number of parameter words that follow the head word.
    function automatic logic [CNT_W-1:0] param_count(input logic [OP_W-1:0] op);
        logic [CNT_W-1:0] n;
        n = '0;
        case (op[7:5])
            3'b000: n = (op == 8'h02) ? 4'd2 : 4'd0;
            3'b001: begin
                case (op[4:2])
                    3'd0:    n = 4'd3;
                    3'd1:    n = 4'd6;
                    3'd2:    n = 4'd4;
                    3'd3:    n = 4'd8;
                    3'd4:    n = 4'd5;
                    3'd5:    n = 4'd8;
                    3'd6:    n = 4'd7;
                    default: n = 4'd11;
                endcase
            end
            3'b010: begin
                case (op[4:3])
                    2'd0:    n = 4'd2;
                    2'd1:    n = 4'd3;
                    2'd2:    n = 4'd3;
                    default: n = 4'd4;
                endcase
            end
            3'b011: begin
                case (op[4:2])
                    3'd0:    n = 4'd2;
                    3'd1:    n = 4'd3;
                    3'd2:    n = 4'd1;
                    3'd3:    n = 4'd0;
                    3'd4:    n = 4'd1;
                    3'd5:    n = 4'd2;
                    3'd6:    n = 4'd1;
                    default: n = 4'd2;
                endcase
            end
            3'b100:          n = 4'd3;
            3'b101, 3'b110:  n = 4'd2;
            default:         n = 4'd0;
        endcase
        return n;
    endfunction

    // How a packet's length is found: fixed count or a terminator scan.
    function automatic trail_e trail_of(input logic [OP_W-1:0] op);
        if (op[7:3] == 5'b01001)      return TR_FLAT;
        else if (op[7:3] == 5'b01011) return TR_SHADED;
        else                          return TR_FIXED;
    endfunction

    // Packet class reported alongside every word.
    function automatic pkt_class_e class_of(input logic [OP_W-1:0] op);
        if (op[7:3] == 5'b11100)       return CL_ENV;
        if (param_count(op) == '0)     return CL_NOP;
        case (op[7:5])
            3'b000:  return CL_FILL;
            3'b001:  return CL_POLYGON;
            3'b010:  return CL_LINE;
            3'b011:  return CL_RECT;
            3'b100:  return CL_COPY;
            3'b101:  return CL_IMG_WR;
            3'b110:  return CL_IMG_RD;
            default: return CL_NOP;
        endcase
    endfunction

endpackage

// File: rtl/cmdf_decode.sv
// Combinational decode of one input word: opcode fields, length rule,
// class, environment target and terminator match. Assumes the word is
// only meaningful as a head when the tracker says so.
module cmdf_decode
    import cmdf_pkg::*;
(
    input  logic [WORD_W-1:0]    word,
    output logic [CNT_W-1:0]     count,
    output trail_e               trail,
    output pkt_class_e           cls,
    output logic                 env_hit,
    output logic [ENV_IDX_W-1:0] env_idx,
    output logic                 term_hit
);
    localparam int OP_LSB = WORD_W - OP_W;

    logic [OP_W-1:0] op;

    // Derive all per-opcode attributes and the terminator test.
    always_comb begin
        op       = word[WORD_W-1:OP_LSB];
        count    = param_count(op);
        trail    = trail_of(op);
        cls      = class_of(op);
        env_hit  = (op[7:3] == 5'b11100);
        env_idx  = op[ENV_IDX_W-1:0];
        term_hit = ((word & TERM_MASK) == TERM_VAL);
    end

endmodule

// File: rtl/cmdf_track.sv
// Packet tracker: keeps the word index inside the open packet, decides
// which accepted word closes it, and registers the word with its flags.
// Assumes decode inputs describe the word on 'word' in the same cycle.
// The index saturates; a separate parity bit keeps the shaded stride.
module cmdf_track
    import cmdf_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  dec_count,
    input  trail_e            dec_trail,
    input  pkt_class_e        dec_cls,
    input  logic              term_hit,
    output logic              at_head,
    output logic              mark_valid,
    output logic [WORD_W-1:0] mark_data,
    output logic              mark_start,
    output logic              mark_end,
    output pkt_class_e        mark_class
);
    localparam logic [IDX_W-1:0] IDX_MAX     = '1;
    localparam logic [IDX_W-1:0] FLAT_FIRST  = IDX_W'(3);
    localparam logic [IDX_W-1:0] SHADE_FIRST = IDX_W'(4);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic             odd_q;
    logic [CNT_W-1:0] last_q;
    trail_e           trail_q;
    pkt_class_e       cls_q;
    logic             end_now;

    assign at_head = !busy_q;

    // Decide whether the word being accepted completes its packet.
    always_comb begin
        if (!busy_q) begin
            end_now = (dec_trail == TR_FIXED) && (dec_count == '0);
        end else begin
            case (trail_q)
                TR_FLAT:   end_now = (idx_q >= FLAT_FIRST) && term_hit;
                TR_SHADED: end_now = (idx_q >= SHADE_FIRST) && !odd_q && term_hit;
                default:   end_now = (idx_q == IDX_W'(last_q));
            endcase
        end
    end

    // Advance the in-packet position on every accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            odd_q   <= 1'b0;
            last_q  <= '0;
            trail_q <= TR_FIXED;
            cls_q   <= CL_NOP;
        end else if (accept) begin
            if (end_now) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
                odd_q  <= 1'b0;
            end else if (!busy_q) begin
                busy_q  <= 1'b1;
                idx_q   <= IDX_W'(1);
                odd_q   <= 1'b1;
                last_q  <= dec_count;
                trail_q <= dec_trail;
                cls_q   <= dec_cls;
            end else begin
                if (idx_q != IDX_MAX) idx_q <= idx_q + IDX_W'(1);
                odd_q <= !odd_q;
            end
        end
    end

    // Register the accepted word together with its framing flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_valid <= 1'b0;
            mark_data  <= '0;
            mark_start <= 1'b0;
            mark_end   <= 1'b0;
            mark_class <= CL_NOP;
        end else begin
            mark_valid <= accept;
            if (accept) begin
                mark_data  <= word;
                mark_start <= !busy_q;
                mark_end   <= end_now;
                mark_class <= busy_q ? cls_q : dec_cls;
            end
        end
    end

    // R9: a framed word is only ever presented after an acceptance.
    p_mark_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mark_valid |-> $past(accept));

    // R1: a fixed-length packet never runs past its last index.
    p_fixed_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && trail_q == TR_FIXED) |-> (idx_q <= IDX_W'(last_q)));

    // R1: a head flag only marks a word taken while no packet was open.
    p_head_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_valid && mark_start) |-> $past(!busy_q));

    // R4: a shaded polyline never closes on an odd index.
    p_shaded_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && busy_q && trail_q == TR_SHADED && odd_q) |=> busy_q);

endmodule

// File: rtl/cmdf_envbank.sv
// Bank of environment registers, one whole word each, written by index.
// Assumes at most one write per cycle.
module cmdf_envbank
    import cmdf_pkg::*;
#(
    parameter int NREG = ENV_N
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ENV_IDX_W-1:0]     widx,
    input  logic [WORD_W-1:0]        wdata,
    output logic [NREG*WORD_W-1:0]   regs_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [WORD_W-1:0] r_q;

        // Hold one environment word; replace it only on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                r_q <= '0;
            else if (we && widx == ENV_IDX_W'(g))      r_q <= wdata;
        end

        assign regs_flat[g*WORD_W +: WORD_W] = r_q;
    end

    // R7: without a write the whole bank keeps its contents.
    p_env_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs_flat));

endmodule

// File: rtl/cmd_framer.sv
// Top of the command framer: accepts words, decodes heads, tracks packet
// boundaries and feeds environment commands to the register bank.
// Assumes a synchronous active-low reset held for at least one edge.
module cmd_framer
    import cmdf_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [31:0]               in_data,
    output logic                      in_ready,
    output logic                      mark_valid,
    output logic [31:0]               mark_data,
    output logic                      mark_start,
    output logic                      mark_end,
    output logic [3:0]                mark_class,
    output logic [ENV_N*WORD_W-1:0]   env_flat
);
    logic                 ready_q;
    logic                 accept;
    logic [CNT_W-1:0]     dec_count;
    trail_e               dec_trail;
    pkt_class_e           dec_cls;
    logic                 dec_env;
    logic [ENV_IDX_W-1:0] dec_env_idx;
    logic                 dec_term;
    logic                 at_head;
    pkt_class_e           mark_cls_e;

    // Open the input one edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    assign in_ready   = ready_q;
    assign accept     = in_valid && ready_q;
    assign mark_class = mark_cls_e;

    cmdf_decode u_decode (
        .word     (in_data),
        .count    (dec_count),
        .trail    (dec_trail),
        .cls      (dec_cls),
        .env_hit  (dec_env),
        .env_idx  (dec_env_idx),
        .term_hit (dec_term)
    );

    cmdf_track #(.IDX_W(IDX_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .word       (in_data),
        .dec_count  (dec_count),
        .dec_trail  (dec_trail),
        .dec_cls    (dec_cls),
        .term_hit   (dec_term),
        .at_head    (at_head),
        .mark_valid (mark_valid),
        .mark_data  (mark_data),
        .mark_start (mark_start),
        .mark_end   (mark_end),
        .mark_class (mark_cls_e)
    );

    cmdf_envbank #(.NREG(ENV_N)) u_env (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (accept && at_head && dec_env),
        .widx      (dec_env_idx),
        .wdata     (in_data),
        .regs_flat (env_flat)
    );

    // R10: out of reset the input is ready on every cycle.
    p_ready_after_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);

endmodule

// File: tb/cmd_framer_tb.sv
module cmd_framer_tb;
    import cmdf_pkg::*;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_data = '0;
    logic         in_ready, mark_valid, mark_start, mark_end;
    logic [31:0]  mark_data;
    logic [3:0]   mark_class;
    logic [255:0] env_flat;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmd_framer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .mark_valid(mark_valid), .mark_data(mark_data),
        .mark_start(mark_start), .mark_end(mark_end), .mark_class(mark_class),
        .env_flat(env_flat)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Drive one word, then sample the framing one cycle after acceptance.
    task automatic put(input logic [31:0] w, input bit s, input bit e,
                       input logic [3:0] c, input string req);
        logic [31:0] act, exp;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(posedge clk);
        #1;
        act = {25'd0, mark_valid, mark_start, mark_end, mark_class};
        exp = {25'd0, 1'b1, s, e, c};
        chk(act == exp && mark_data == w, req, "flags v/s/e/cls", act, exp);
    endtask

    task automatic idle(input int n, input string req);
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            chk(mark_valid == 1'b0, req, "valid in gap", {31'd0, mark_valid}, 32'd0);
        end
    endtask

    function automatic int exp_count(input logic [7:0] op);
        if (op == 8'h02) return 2;
        if (op >= 8'h20 && op <= 8'h3F) begin
            case (op[4:2])
                0: return 3;  1: return 6;  2: return 4;  3: return 8;
                4: return 5;  5: return 8;  6: return 7;  default: return 11;
            endcase
        end
        if (op >= 8'h40 && op <= 8'h47) return 2;
        if (op >= 8'h50 && op <= 8'h57) return 3;
        if (op >= 8'h60 && op <= 8'h7F) begin
            case (op[4:2])
                0: return 2;  1: return 3;  2: return 1;  3: return 0;
                4: return 1;  5: return 2;  6: return 1;  default: return 2;
            endcase
        end
        if (op >= 8'h80 && op <= 8'h9F) return 3;
        if (op >= 8'hA0 && op <= 8'hDF) return 2;
        return 0;
    endfunction

    function automatic logic [3:0] exp_cls(input logic [7:0] op);
        if (op >= 8'hE0 && op <= 8'hE7) return 4'd8;
        if (exp_count(op) == 0) return 4'd0;
        if (op < 8'h20) return 4'd1;
        if (op < 8'h40) return 4'd2;
        if (op < 8'h60) return 4'd3;
        if (op < 8'h80) return 4'd4;
        if (op < 8'hA0) return 4'd5;
        if (op < 8'hC0) return 4'd6;
        return 4'd7;
    endfunction

    // Fixed-length packet; parameter words look like terminators on purpose.
    task automatic send_fixed(input logic [7:0] op, input string req);
        int n = exp_count(op);
        logic [3:0] c = exp_cls(op);
        put({op, 24'h13_5791}, 1'b1, n == 0, c, req);
        for (int i = 1; i <= n; i++)
            put(32'h5555_5555, 1'b0, i == n, c, req);
    endtask

    task automatic send_flat(input logic [7:0] op, input int nv, input bit early, input string req);
        put({op, 24'h00_00FF}, 1'b1, 1'b0, 4'd3, req);
        for (int i = 1; i <= nv; i++)
            put((early && i == 1) ? 32'h5000_5000 : 32'h0001_0002, 1'b0, 1'b0, 4'd3, req);
        put(32'h5555_5555, 1'b0, 1'b1, 4'd3, req);
    endtask

    task automatic send_shaded(input logic [7:0] op, input int m, input bit oddterm, input string req);
        put({op, 24'h80_8080}, 1'b1, 1'b0, 4'd3, req);
        for (int i = 1; i < 2 * m; i++) begin
            if (i[0]) put((oddterm && i == 3) ? 32'h5A5A_5A5A : 32'h0010_0020, 1'b0, 1'b0, 4'd3, req);
            else      put(32'h00FF_FFFF, 1'b0, 1'b0, 4'd3, req);
        end
        put(32'h5000_5000, 1'b0, 1'b1, 4'd3, req);
    endtask

    task automatic t_reset_state();
        @(posedge clk);
        #1;
        chk(in_ready == 1'b0, "R10", "ready in reset", {31'd0, in_ready}, 32'd0);
        chk(mark_valid == 1'b0, "R10", "valid in reset", {31'd0, mark_valid}, 32'd0);
        chk(env_flat == '0, "R10", "env in reset", env_flat[31:0], 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(in_ready == 1'b1, "R10", "ready after reset", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_fixed();
        send_fixed(8'h20, "R1");
        send_fixed(8'h27, "R1");
        send_fixed(8'h2C, "R1");
        send_fixed(8'h3E, "R1");
        send_fixed(8'h02, "R2");
        send_fixed(8'h42, "R11");
        send_fixed(8'h55, "R11");
        send_fixed(8'h68, "R11");
        send_fixed(8'h7D, "R11");
        idle(1, "R9");
    endtask

    task automatic t_poly();
        send_flat(8'h48, 2, 1'b0, "R3");
        send_flat(8'h4F, 5, 1'b1, "R3");
        send_shaded(8'h58, 2, 1'b0, "R4");
        send_shaded(8'h5C, 4, 1'b1, "R4");
        idle(1, "R9");
    endtask

    task automatic t_image_copy();
        send_fixed(8'hA0, "R5");
        send_fixed(8'hBF, "R5");
        send_fixed(8'hC4, "R5");
        send_fixed(8'hDF, "R5");
        send_fixed(8'h80, "R6");
        send_fixed(8'h9F, "R6");
        idle(1, "R9");
    endtask

    task automatic t_env_nop();
        put(32'hE200_0011, 1'b1, 1'b1, 4'd8, "R7");
        put(32'hE3AB_CDEF, 1'b1, 1'b1, 4'd8, "R7");
        chk(env_flat[3*32 +: 32] == 32'hE3AB_CDEF, "R7", "env3", env_flat[3*32 +: 32], 32'hE3AB_CDEF);
        chk(env_flat[2*32 +: 32] == 32'hE200_0011, "R7", "env2 kept", env_flat[2*32 +: 32], 32'hE200_0011);
        put(32'hE700_0007, 1'b1, 1'b1, 4'd8, "R7");
        chk(env_flat[7*32 +: 32] == 32'hE700_0007, "R7", "env7", env_flat[7*32 +: 32], 32'hE700_0007);
        put(32'h0000_0000, 1'b1, 1'b1, 4'd0, "R8");
        put(32'h1F12_3456, 1'b1, 1'b1, 4'd0, "R8");
        put(32'h6C00_0000, 1'b1, 1'b1, 4'd0, "R8");
        put(32'hE812_3456, 1'b1, 1'b1, 4'd0, "R8");
        chk(env_flat[0 +: 32] == 32'd0, "R8", "env0 untouched", env_flat[0 +: 32], 32'd0);
        chk(env_flat[3*32 +: 32] == 32'hE3AB_CDEF, "R8", "env3 untouched", env_flat[3*32 +: 32], 32'hE3AB_CDEF);
        idle(1, "R9");
    endtask

    task automatic t_gap();
        put(32'h2800_0000, 1'b1, 1'b0, 4'd2, "R9");
        put(32'h0000_0001, 1'b0, 1'b0, 4'd2, "R9");
        idle(3, "R9");
        put(32'h0000_0002, 1'b0, 1'b0, 4'd2, "R9");
        idle(2, "R9");
        put(32'h0000_0003, 1'b0, 1'b0, 4'd2, "R9");
        put(32'h0000_0004, 1'b0, 1'b1, 4'd2, "R9");
        idle(1, "R9");
    endtask

    task automatic t_mid_reset();
        put(32'hE512_3456, 1'b1, 1'b1, 4'd8, "R10");
        put(32'h2800_0000, 1'b1, 1'b0, 4'd2, "R10");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk(env_flat == '0, "R10", "env cleared", env_flat[5*32 +: 32], 32'd0);
        chk(in_ready == 1'b0, "R10", "ready low", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        put(32'hE1AA_0001, 1'b1, 1'b1, 4'd8, "R10");
        idle(1, "R10");
    endtask

    task automatic t_random();
        for (int k = 0; k < 60; k++) begin
            logic [7:0] op = 8'($urandom_range(0, 255));
            if (op[7:3] == 5'b01001)      send_flat(op, int'($urandom_range(2, 9)), 1'($urandom_range(0, 1)), "R3");
            else if (op[7:3] == 5'b01011) send_shaded(op, int'($urandom_range(2, 6)), 1'($urandom_range(0, 1)), "R4");
            else                          send_fixed(op, "R1");
            if ($urandom_range(0, 3) == 0) idle(1, "R9");
        end
        idle(1, "R9");
    endtask

    initial begin
        void'($urandom(32'h1234));
        t_reset_state();
        t_fixed();
        t_poly();
        t_image_copy();
        t_env_nop();
        t_gap();
        t_mid_reset();
        t_random();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule